// File: doc/BRIEF.md
# Bitmap Identifier Packet Filter

This block sits on a byte-wide transport packet stream and lets through only the packets whose identifier is enabled in a one-bit-per-identifier table. Every packet has a fixed length and is marked by a start flag on its first byte. The first eight bytes are joined into a 64-bit word, with the first byte in the most significant position. A slice of that word, set by a bit offset and a bit width, is the packet identifier. The identifier addresses the table, and a set bit means the packet is kept.

Bytes enter a packet buffer as they arrive. Once byte 7 has been seen, a pipelined lookup produces a keep/reject decision and places it in a short decision queue. A reader state machine has three states. In WAIT_DECISION it pops the next decision. On a keep it takes the transition to FORWARD, and on a reject it takes the transition to DISCARD. In FORWARD it emits one packet length of bytes from the buffer, and in DISCARD it drops one packet length of bytes. In both, the last byte of the packet returns it to WAIT_DECISION. When the global enable is low, every decision is a keep. The table is changed through a write port that sets or clears one bit at a time. Reset clears the whole table.

Top module: `pidf_filter`

## Requirements
- R1: The header word is byte 0 in bits 63:56 down to byte 7 in bits 7:0. The identifier is bits offset+width-1 down to offset of that word. Bits above position 63 read as zero. With offset 40 and width 13, the identifier is the low 5 bits of byte 1 followed by byte 2.
- R2: Offset and width are programmable. With offset 0 and width 8, the identifier is byte 7.
- R3: With the enable high, a packet is forwarded exactly when the table bit at its identifier is 1, and discarded otherwise.
- R4: With the enable low (as sampled at byte 7), every packet is forwarded whatever the table holds.
- R5: After reset every table bit is 0, so with the enable high every packet is discarded.
- R6: A table write with tw_set=1 sets bit tw_id, and with tw_set=0 clears it. Table bit k belongs to identifier value k, including values 0 and 2^ID_W-1.
- R7: A forwarded packet leaves as all PKT_LEN bytes, unchanged and in order, with out_sop high on its first byte only.
- R8: A discarded packet produces no output bytes. Forwarded packets keep their arrival order in back-to-back streams that mix kept and rejected packets.
- R9: A table write accepted in the same cycle as byte 7 or earlier applies to that packet's lookup. A write accepted after byte 7 applies from the next packet.
- R10: During and right after reset, out_valid, out_sop and out_data are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is byte 0 of a packet |
| in_data | input | 8 | Input byte |
| cfg_en | input | 1 | Filter enable; low forwards everything |
| cfg_offset | input | 6 | Bit offset of the identifier slice |
| cfg_width | input | $clog2(ID_W+1) | Bit width of the identifier slice (clamped to ID_W) |
| tw_en | input | 1 | Table write strobe |
| tw_id | input | ID_W | Table bit to write |
| tw_set | input | 1 | Value to write: 1 sets, 0 clears |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | Output byte is byte 0 of a forwarded packet |
| out_data | output | 8 | Output byte |

## Verification
The bench builds the filter with PKT_LEN=24 and BUF_DEPTH=32, and keeps the full 13-bit identifier and 8192-bit table. Short packets let many back-to-back packets be sent in a small run. That brings the case where a second decision waits in the queue while the reader is still draining the previous packet, and the buffer near its fullest, within reach. With the full identifier width, the extreme table bits 0 and 8191 can be set and tested, and so can masking of the bits in byte 1 that lie outside the slice.

// File: rtl/pidf_pkg.sv
package pidf_pkg;
    localparam int HDR_BYTES = 8;
    localparam int HDR_BITS  = HDR_BYTES * 8;
    localparam int OFF_W     = $clog2(HDR_BITS);

    typedef enum logic [1:0] {
        RD_WAIT = 2'd0,
        RD_PASS = 2'd1,
        RD_DROP = 2'd2
    } rd_state_e;
endpackage

// File: rtl/pidf_byte_fifo.sv
module pidf_byte_fifo #(
    parameter int DEPTH = 256,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wr_ptr, rd_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_data;
    end

    assign rd_data = mem[rd_ptr[AW-1:0]];
    assign empty   = (wr_ptr == rd_ptr);
    assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
endmodule

// File: rtl/pidf_hdr_slice.sv
module pidf_hdr_slice
    import pidf_pkg::*;
#(
    parameter int ID_W  = 13,
    parameter int WID_W = $clog2(ID_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [7:0]       in_data,
    input  logic             cfg_en,
    input  logic [OFF_W-1:0] cfg_offset,
    input  logic [WID_W-1:0] cfg_width,
    output logic             lk_valid,
    output logic [ID_W-1:0]  lk_id,
    output logic             lk_bypass
);
    logic [HDR_BITS-9:0] hdr_q;
    logic [2:0]          cnt_q;
    logic                in_hdr_q;
    logic [HDR_BITS-1:0] word;
    logic [ID_W-1:0]     id_c;
    logic [WID_W-1:0]    wid_eff;
    logic                fire;

    assign word    = {hdr_q, in_data};
    assign fire    = in_valid && !in_sop && in_hdr_q && (cnt_q == 3'd7);
    assign wid_eff = (cfg_width > WID_W'(ID_W)) ? WID_W'(ID_W) : cfg_width;

    always_comb begin
        for (int i = 0; i < ID_W; i++) begin
            logic [OFF_W:0] idx;
            idx = {1'b0, cfg_offset} + (OFF_W+1)'(i);
            id_c[i] = (WID_W'(i) < wid_eff) && !idx[OFF_W] && word[idx[OFF_W-1:0]];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q    <= '0;
            cnt_q    <= '0;
            in_hdr_q <= 1'b0;
        end else if (in_valid) begin
            if (in_sop) begin
                hdr_q    <= {{(HDR_BITS-16){1'b0}}, in_data};
                cnt_q    <= 3'd1;
                in_hdr_q <= 1'b1;
            end else if (in_hdr_q) begin
                hdr_q <= {hdr_q[HDR_BITS-17:0], in_data};
                cnt_q <= cnt_q + 3'd1;
                if (cnt_q == 3'd7) in_hdr_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_valid  <= 1'b0;
            lk_id     <= '0;
            lk_bypass <= 1'b0;
        end else begin
            lk_valid <= fire;
            if (fire) begin
                lk_id     <= id_c;
                lk_bypass <= !cfg_en;
            end
        end
    end

    // R1
    one_lookup_per_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> !lk_valid);
endmodule

// File: rtl/pidf_bitmap.sv
module pidf_bitmap #(
    parameter int ID_W   = 13,
    parameter int WORD_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tw_en,
    input  logic [ID_W-1:0] tw_id,
    input  logic            tw_set,
    input  logic            lk_valid,
    input  logic [ID_W-1:0] lk_id,
    input  logic            lk_bypass,
    output logic            dec_valid,
    output logic            dec_pass
);
    localparam int SEL_W  = $clog2(WORD_W);
    localparam int ADDR_W = ID_W - SEL_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [WORD_W-1:0] tbl [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) tbl[a] <= '0;
        end else if (tw_en) begin
            tbl[tw_id[ID_W-1:SEL_W]][tw_id[SEL_W-1:0]] <= tw_set;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            dec_pass  <= 1'b0;
        end else begin
            dec_valid <= lk_valid;
            if (lk_valid)
                dec_pass <= lk_bypass || tbl[lk_id[ID_W-1:SEL_W]][lk_id[SEL_W-1:0]];
        end
    end

    // R6
    write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_bypass && $past(tw_en) && (lk_id == $past(tw_id)) && !(tw_en && tw_id == lk_id))
        |=> (dec_pass == $past(tw_set, 2)));
    // R4
    bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_bypass) |=> dec_pass);
endmodule

// File: rtl/pidf_filter.sv
module pidf_filter
    import pidf_pkg::*;
#(
    parameter int ID_W      = 13,
    parameter int PKT_LEN   = 188,
    parameter int BUF_DEPTH = 256,
    parameter int WORD_W    = 32,
    parameter int DQ_DEPTH  = 4,
    localparam int WID_W    = $clog2(ID_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [7:0]       in_data,
    input  logic             cfg_en,
    input  logic [OFF_W-1:0] cfg_offset,
    input  logic [WID_W-1:0] cfg_width,
    input  logic             tw_en,
    input  logic [ID_W-1:0]  tw_id,
    input  logic             tw_set,
    output logic             out_valid,
    output logic             out_sop,
    output logic [7:0]       out_data
);
    localparam int CNT_W = $clog2(PKT_LEN + 1);

    logic            lk_valid, lk_bypass, dec_valid, dec_pass;
    logic [ID_W-1:0] lk_id;
    logic            dq_pop, dq_empty, dq_full, dq_pass;
    logic            byte_pop, buf_empty, buf_full;
    logic [7:0]      buf_rd;

    rd_state_e       st_q, st_d;
    logic [CNT_W-1:0] rem_q, rem_d;

    pidf_hdr_slice #(.ID_W(ID_W), .WID_W(WID_W)) u_slice (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_data(in_data), .cfg_en(cfg_en), .cfg_offset(cfg_offset),
        .cfg_width(cfg_width), .lk_valid(lk_valid), .lk_id(lk_id),
        .lk_bypass(lk_bypass)
    );

    pidf_bitmap #(.ID_W(ID_W), .WORD_W(WORD_W)) u_map (
        .clk(clk), .rst_n(rst_n), .tw_en(tw_en), .tw_id(tw_id), .tw_set(tw_set),
        .lk_valid(lk_valid), .lk_id(lk_id), .lk_bypass(lk_bypass),
        .dec_valid(dec_valid), .dec_pass(dec_pass)
    );

    pidf_byte_fifo #(.DEPTH(DQ_DEPTH), .W(1)) u_decq (
        .clk(clk), .rst_n(rst_n), .wr_en(dec_valid), .wr_data(dec_pass),
        .rd_en(dq_pop), .rd_data(dq_pass), .empty(dq_empty), .full(dq_full)
    );

    pidf_byte_fifo #(.DEPTH(BUF_DEPTH), .W(8)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(in_valid), .wr_data(in_data),
        .rd_en(byte_pop), .rd_data(buf_rd), .empty(buf_empty), .full(buf_full)
    );

    assign dq_pop   = (st_q == RD_WAIT) && !dq_empty;
    assign byte_pop = (st_q != RD_WAIT) && !buf_empty;

    always_comb begin
        st_d  = st_q;
        rem_d = rem_q;
        unique case (st_q)
            RD_WAIT: begin
                if (dq_pop) begin
                    st_d  = dq_pass ? RD_PASS : RD_DROP;
                    rem_d = CNT_W'(PKT_LEN);
                end
            end
            RD_PASS, RD_DROP: begin
                if (byte_pop) begin
                    rem_d = rem_q - 1'b1;
                    if (rem_q == CNT_W'(1)) st_d = RD_WAIT;
                end
            end
            default: st_d = RD_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RD_WAIT;
            rem_q <= '0;
        end else begin
            st_q  <= st_d;
            rem_q <= rem_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= byte_pop && (st_q == RD_PASS);
            out_sop   <= byte_pop && (st_q == RD_PASS) && (rem_q == CNT_W'(PKT_LEN));
            if (byte_pop && (st_q == RD_PASS)) out_data <= buf_rd;
        end
    end

    // R7
    sop_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> out_valid);
    // R7
    buf_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> !buf_full);
    // R8
    out_only_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(st_q == RD_PASS));
    // R8
    decq_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> !dq_full);
endmodule

// File: tb/sim_pidf_filter.sv
module sim_pidf_filter;
    localparam int ID_W    = 13;
    localparam int PKT_LEN = 24;
    localparam int WID_W   = $clog2(ID_W + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0, in_sop = 1'b0;
    logic [7:0]       in_data = '0;
    logic             cfg_en = 1'b1;
    logic [5:0]       cfg_offset = 6'd40;
    logic [WID_W-1:0] cfg_width = WID_W'(13);
    logic             tw_en = 1'b0, tw_set = 1'b0;
    logic [ID_W-1:0]  tw_id = '0;
    logic             out_valid, out_sop;
    logic [7:0]       out_data;

    always #4 clk = ~clk;

    pidf_filter #(.ID_W(ID_W), .PKT_LEN(PKT_LEN), .BUF_DEPTH(32)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_data(in_data), .cfg_en(cfg_en), .cfg_offset(cfg_offset),
        .cfg_width(cfg_width), .tw_en(tw_en), .tw_id(tw_id), .tw_set(tw_set),
        .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data)
    );

    int errors = 0, checks = 0;
    int rx_n = 0, exp_n = 0, mark = 0;
    bit finished = 0;
    logic [7:0] rx_d [2048];
    logic       rx_s [2048];
    logic [7:0] ex_d [2048];
    logic       ex_s [2048];

    // {enable, identifier, expected forward}
    localparam logic [14:0] VEC [8] = '{
        {1'b1, 13'h0100, 1'b1},
        {1'b1, 13'h0101, 1'b0},
        {1'b1, 13'h1FFF, 1'b1},
        {1'b1, 13'h0000, 1'b1},
        {1'b1, 13'h1FFE, 1'b0},
        {1'b0, 13'h0101, 1'b1},
        {1'b0, 13'h0555, 1'b1},
        {1'b1, 13'h0555, 1'b0}
    };

    always @(negedge clk) begin
        if (out_valid) begin
            rx_d[rx_n] = out_data;
            rx_s[rx_n] = out_sop;
            rx_n = rx_n + 1;
        end
    end

    function automatic logic [63:0] hdr_for(input logic [12:0] id);
        return {8'h47, 3'b010, id[12:8], id[7:0], 8'h10, 8'h11, 8'h12, 8'h13, 8'hA5};
    endfunction

    task automatic send_pkt(input logic [63:0] hdr, input logic [7:0] seed, input bit pass,
                            input int wr_at, input logic [12:0] wid, input bit wset);
        for (int i = 0; i < PKT_LEN; i++) begin
            logic [7:0] b;
            b = (i < 8) ? hdr[63-8*i -: 8] : seed + 8'(i);
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = (i == 0);
            in_data  = b;
            tw_en    = (i == wr_at);
            tw_id    = wid;
            tw_set   = wset;
            if (pass) begin
                ex_d[exp_n] = b;
                ex_s[exp_n] = (i == 0);
                exp_n = exp_n + 1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        tw_en    = 1'b0;
    endtask

    task automatic twrite(input logic [12:0] id, input bit v);
        @(negedge clk);
        tw_en = 1'b1; tw_id = id; tw_set = v;
        @(negedge clk);
        tw_en = 1'b0;
    endtask

    task automatic drain();
        repeat (3 * PKT_LEN) @(negedge clk);
    endtask

    task automatic chk_stream(input string req);
        checks++;
        if (rx_n != exp_n) begin
            errors++;
            $display("FAIL %s: byte count actual=%0d expected=%0d", req, rx_n, exp_n);
        end
        checks++;
        for (int j = mark; j < exp_n; j++) begin
            if (j >= rx_n || rx_d[j] != ex_d[j] || rx_s[j] != ex_s[j]) begin
                errors++;
                if (j < rx_n)
                    $display("FAIL %s: byte %0d actual=%h/sop%0d expected=%h/sop%0d",
                             req, j, rx_d[j], rx_s[j], ex_d[j], ex_s[j]);
                else
                    $display("FAIL %s: byte %0d missing, expected=%h", req, j, ex_d[j]);
                break;
            end
        end
        mark = exp_n;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs idle during reset
        checks++;
        if (out_valid !== 1'b0 || out_sop !== 1'b0 || out_data !== 8'h00) begin
            errors++;
            $display("FAIL R10: outputs actual=%b%b%h expected=000", out_valid, out_sop, out_data);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R10: out_valid after reset actual=%b expected=0", out_valid);
        end

        // R5: empty table blocks all with enable high
        send_pkt(hdr_for(13'h0100), 8'h20, 1'b0, -1, '0, 1'b0);
        send_pkt(hdr_for(13'h0000), 8'h30, 1'b0, -1, '0, 1'b0);
        drain();
        chk_stream("R5");

        // R6: set entries, including extremes 0 and 8191
        twrite(13'h0100, 1'b1);
        twrite(13'h1FFF, 1'b1);
        twrite(13'h0000, 1'b1);

        // R1 R3 R4 R7: vector table, one packet each
        for (int v = 0; v < 8; v++) begin
            cfg_en = VEC[v][14];
            send_pkt(hdr_for(VEC[v][13:1]), 8'(8'h40 + 16*v), VEC[v][0], -1, '0, 1'b0);
            drain();
            chk_stream(VEC[v][14] ? "R1/R3/R7" : "R4");
        end
        cfg_en = 1'b1;

        // R6: clearing an entry blocks it again
        twrite(13'h0100, 1'b0);
        send_pkt(hdr_for(13'h0100), 8'hB0, 1'b0, -1, '0, 1'b0);
        send_pkt(hdr_for(13'h1FFF), 8'hB8, 1'b1, -1, '0, 1'b0);
        drain();
        chk_stream("R6");

        // R2: offset 0, width 8 selects byte 7
        cfg_offset = 6'd0;
        cfg_width  = WID_W'(8);
        twrite(13'h0042, 1'b1);
        send_pkt({56'h47_01_00_10_11_12_13, 8'h42}, 8'hC0, 1'b1, -1, '0, 1'b0);
        send_pkt({56'h47_01_00_10_11_12_13, 8'h43}, 8'hC8, 1'b0, -1, '0, 1'b0);
        drain();
        chk_stream("R2");
        cfg_offset = 6'd40;
        cfg_width  = WID_W'(13);

        // R9: write before byte 7 counts, write after byte 7 waits a packet
        send_pkt(hdr_for(13'h0300), 8'hD0, 1'b1, 3, 13'h0300, 1'b1);
        send_pkt(hdr_for(13'h0200), 8'hD8, 1'b0, 12, 13'h0200, 1'b1);
        send_pkt(hdr_for(13'h0200), 8'hE0, 1'b1, -1, '0, 1'b0);
        drain();
        chk_stream("R9");

        // R8: back-to-back mix keeps order and drops rejected packets
        for (int k = 0; k < 8; k++) begin
            logic [12:0] id;
            id = (k % 3 == 1) ? 13'h0101 : ((k % 2 == 0) ? 13'h1FFF : 13'h0000);
            send_pkt(hdr_for(id), 8'(8'h10 * k + 8'h05), (k % 3 != 1), -1, '0, 1'b0);
        end
        drain();
        chk_stream("R8");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule